// File: doc/BRIEF.md
# Paired-Register Wide Operand File

This block is a register file of 64 entries, each 64 bits wide, that feeds two issue lanes. Each lane has one combinational read port and one write port, and in normal (narrow) operation the lanes work independently. The same storage can also be treated as 32 wide registers of 128 bits. A wide register with pair index p keeps its low half in entry 2p and its high half in entry 2p+1. No entry is physically 128 bits wide.

When lane 0 presents a wide operation, the file merges the ports of both lanes onto one even/odd pair. Lane 0's read port returns the low half and lane 1's read port returns the high half. Both halves are written on the same clock edge, with the low half taken from lane 0's write data and the high half from lane 1's write data. Only one instruction issues in such a cycle. A valid lane 1 request in that cycle is stalled and reported through `l1_stall`, so that upstream logic holds it. The file stores no mode bit, so any pair can be accessed either as one wide value or as two independent narrow values.

A two-state steering machine makes sure a stalled lane 1 request is not starved:
- **Steering states:** `LANE_FREE` is the normal state. `LANE_OWED` means lane 1 was stalled in the previous cycle.
- **FREE_TO_OWED:** taken when a wide operation issues while lane 1 is valid.
- **OWED_TO_FREE:** taken unconditionally after one cycle.
- **FREE_HOLD:** every other case, which stays in `LANE_FREE`.

In `LANE_OWED`, lane 1 has priority. A wide request from lane 0 that would collide with a valid lane 1 is stalled instead, and `l0_stall` is raised.

Top module: `pf_regfile`

## Requirements
- R1: After reset, every entry reads as zero on both read ports, and `l0_stall` and `l1_stall` are low.
- R2: In narrow mode, each lane's read port returns the entry at its own read address combinationally. A write that is accepted on an edge becomes visible only after that edge, because there is no same-cycle bypass.
- R3: When both lanes write the same entry in the same narrow cycle, lane 1's data is stored.
- R4: An issued wide write (`l0_valid`=1, `l0_wide`=1, `l0_wen`=1, not stalled) stores `l0_wdata` in entry {`l0_waddr`[5:1],0} and `l1_wdata` in entry {`l0_waddr`[5:1],1}. Bit 0 of `l0_waddr`, and lane 1's write address and write enable, are ignored.
- R5: While a wide operation issues, `l0_rdata` returns entry {`l0_raddr`[5:1],0} and `l1_rdata` returns entry {`l0_raddr`[5:1],1}. `l1_raddr` is ignored.
- R6: In `LANE_FREE`, an issuing wide operation with `l1_valid`=1 raises `l1_stall` in that cycle, and lane 1's write does not happen.
- R7: In the cycle after a lane 1 stall (`LANE_OWED`), lane 1 is never stalled. If lane 0 requests a wide operation while `l1_valid`=1, `l0_stall` is raised and lane 0's write does not happen. If `l1_valid`=0, the wide operation issues without a stall.
- R8: Entries written by wide operations can be read as narrow values, and entries written narrowly can be read as wide values, with no mode stored per entry.
- R9: `l1_stall` is asserted only when lane 0 has a valid wide request, and `l0_stall` and `l1_stall` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears all entries and the steering state |
| l0_valid | input | 1 | Lane 0 has an instruction |
| l0_wide | input | 1 | Lane 0 instruction is a 128-bit pair operation |
| l0_raddr | input | 6 | Lane 0 read address (pair index in bits 5:1 when wide) |
| l0_waddr | input | 6 | Lane 0 write address (pair index in bits 5:1 when wide) |
| l0_wen | input | 1 | Lane 0 write enable (both halves when wide) |
| l0_wdata | input | 64 | Lane 0 write data; low half when wide |
| l1_valid | input | 1 | Lane 1 has an instruction |
| l1_raddr | input | 6 | Lane 1 read address |
| l1_waddr | input | 6 | Lane 1 write address |
| l1_wen | input | 1 | Lane 1 write enable |
| l1_wdata | input | 64 | Lane 1 write data; high half when wide |
| l0_rdata | output | 64 | Lane 0 read data; low half when wide |
| l1_rdata | output | 64 | Lane 1 read data; high half when wide |
| l0_stall | output | 1 | Lane 0 request held this cycle |
| l1_stall | output | 1 | Lane 1 request held this cycle |

## Verification
A wrong steering state shows on the stall outputs in the same cycle as the request. Examples are a lane 1 stall that does not release, a lane 0 stall without a preceding lane 1 stall, or both stalls high together. Faulty pair addressing or port merging shows on the read ports one cycle after the affected write, either as a half landing in the wrong entry or as the high half appearing on the wrong lane. A wrong collision priority, or a write that leaks through during a stall, shows on the read ports on the cycle right after the edge, when the entry is read back.

// File: rtl/pf_pkg.sv
package pf_pkg;
    typedef enum logic [0:0] {
        LANE_FREE = 1'b0,
        LANE_OWED = 1'b1
    } steer_e;
endpackage

// File: rtl/pf_lane_steer.sv
module pf_lane_steer
    import pf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic l0_valid,
    input  logic l0_wide,
    input  logic l1_valid,
    output logic l0_go,
    output logic l1_go,
    output logic wide_go,
    output logic l0_stall,
    output logic l1_stall
);
    steer_e state_q;
    steer_e state_d;
    logic   wide_req;

    assign wide_req = l0_valid & l0_wide;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LANE_FREE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = LANE_FREE;
        l0_go    = 1'b0;
        l1_go    = 1'b0;
        wide_go  = 1'b0;
        l0_stall = 1'b0;
        l1_stall = 1'b0;
        unique case (state_q)
            LANE_FREE: begin
                l0_go    = l0_valid;
                wide_go  = wide_req;
                l1_stall = wide_req & l1_valid;
                l1_go    = l1_valid & ~wide_req;
                // FREE_TO_OWED when lane 1 is held, else FREE_HOLD
                state_d  = l1_stall ? LANE_OWED : LANE_FREE;
            end
            LANE_OWED: begin
                l1_go    = l1_valid;
                l0_stall = wide_req & l1_valid;
                l0_go    = l0_valid & ~l0_stall;
                wide_go  = wide_req & ~l0_stall;
                // OWED_TO_FREE unconditionally
                state_d  = LANE_FREE;
            end
            default: state_d = LANE_FREE;
        endcase
    end
endmodule

// File: rtl/pf_port_merge.sv
module pf_port_merge #(
    parameter int DW = 64,
    parameter int AW = 6
) (
    input  logic          wide_go,
    input  logic          l0_go,
    input  logic          l1_go,
    input  logic [AW-1:0] l0_raddr,
    input  logic [AW-1:0] l0_waddr,
    input  logic          l0_wen,
    input  logic [DW-1:0] l0_wdata,
    input  logic [AW-1:0] l1_raddr,
    input  logic [AW-1:0] l1_waddr,
    input  logic          l1_wen,
    input  logic [DW-1:0] l1_wdata,
    output logic [AW-1:0] rd0_addr,
    output logic [AW-1:0] rd1_addr,
    output logic          wr0_en,
    output logic [AW-1:0] wr0_addr,
    output logic [DW-1:0] wr0_data,
    output logic          wr1_en,
    output logic [AW-1:0] wr1_addr,
    output logic [DW-1:0] wr1_data
);
    logic [AW-2:0] rd_pair;
    logic [AW-2:0] wr_pair;

    assign rd_pair = l0_raddr[AW-1:1];
    assign wr_pair = l0_waddr[AW-1:1];

    always_comb begin
        wr0_data = l0_wdata;
        wr1_data = l1_wdata;
        wr0_en   = l0_go & l0_wen;
        if (wide_go) begin
            rd0_addr = {rd_pair, 1'b0};
            rd1_addr = {rd_pair, 1'b1};
            wr0_addr = {wr_pair, 1'b0};
            wr1_addr = {wr_pair, 1'b1};
            wr1_en   = l0_wen;
        end else begin
            rd0_addr = l0_raddr;
            rd1_addr = l1_raddr;
            wr0_addr = l0_waddr;
            wr1_addr = l1_waddr;
            wr1_en   = l1_go & l1_wen;
        end
    end
endmodule

// File: rtl/pf_pair_storage.sv
module pf_pair_storage #(
    parameter int DW      = 64,
    parameter int ENTRIES = 64,
    parameter int AW      = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd0_addr,
    input  logic [AW-1:0] rd1_addr,
    output logic [DW-1:0] rd0_data,
    output logic [DW-1:0] rd1_data,
    input  logic          wr0_en,
    input  logic [AW-1:0] wr0_addr,
    input  logic [DW-1:0] wr0_data,
    input  logic          wr1_en,
    input  logic [AW-1:0] wr1_addr,
    input  logic [DW-1:0] wr1_data
);
    logic [ENTRIES-1:0][DW-1:0] cells;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cell
        logic [DW-1:0] q;
        logic          hit0;
        logic          hit1;
        assign hit0 = wr0_en && (wr0_addr == AW'(i));
        assign hit1 = wr1_en && (wr1_addr == AW'(i));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    q <= '0;
            else if (hit1) q <= wr1_data;   // lane 1 is younger
            else if (hit0) q <= wr0_data;
        end
        assign cells[i] = q;
    end

    assign rd0_data = cells[rd0_addr];
    assign rd1_data = cells[rd1_addr];
endmodule

// File: rtl/pf_regfile.sv
module pf_regfile #(
    parameter int DW      = 64,
    parameter int ENTRIES = 64,
    localparam int AW     = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          l0_valid,
    input  logic          l0_wide,
    input  logic [AW-1:0] l0_raddr,
    input  logic [AW-1:0] l0_waddr,
    input  logic          l0_wen,
    input  logic [DW-1:0] l0_wdata,
    input  logic          l1_valid,
    input  logic [AW-1:0] l1_raddr,
    input  logic [AW-1:0] l1_waddr,
    input  logic          l1_wen,
    input  logic [DW-1:0] l1_wdata,
    output logic [DW-1:0] l0_rdata,
    output logic [DW-1:0] l1_rdata,
    output logic          l0_stall,
    output logic          l1_stall
);
    logic          l0_go, l1_go, wide_go;
    logic [AW-1:0] rd0_addr, rd1_addr, wr0_addr, wr1_addr;
    logic          wr0_en, wr1_en;
    logic [DW-1:0] wr0_data, wr1_data;

    pf_lane_steer u_steer (
        .clk      (clk),
        .rst_n    (rst_n),
        .l0_valid (l0_valid),
        .l0_wide  (l0_wide),
        .l1_valid (l1_valid),
        .l0_go    (l0_go),
        .l1_go    (l1_go),
        .wide_go  (wide_go),
        .l0_stall (l0_stall),
        .l1_stall (l1_stall)
    );

    pf_port_merge #(.DW(DW), .AW(AW)) u_merge (
        .wide_go  (wide_go),
        .l0_go    (l0_go),
        .l1_go    (l1_go),
        .l0_raddr (l0_raddr),
        .l0_waddr (l0_waddr),
        .l0_wen   (l0_wen),
        .l0_wdata (l0_wdata),
        .l1_raddr (l1_raddr),
        .l1_waddr (l1_waddr),
        .l1_wen   (l1_wen),
        .l1_wdata (l1_wdata),
        .rd0_addr (rd0_addr),
        .rd1_addr (rd1_addr),
        .wr0_en   (wr0_en),
        .wr0_addr (wr0_addr),
        .wr0_data (wr0_data),
        .wr1_en   (wr1_en),
        .wr1_addr (wr1_addr),
        .wr1_data (wr1_data)
    );

    pf_pair_storage #(.DW(DW), .ENTRIES(ENTRIES), .AW(AW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd0_addr (rd0_addr),
        .rd1_addr (rd1_addr),
        .rd0_data (l0_rdata),
        .rd1_data (l1_rdata),
        .wr0_en   (wr0_en),
        .wr0_addr (wr0_addr),
        .wr0_data (wr0_data),
        .wr1_en   (wr1_en),
        .wr1_addr (wr1_addr),
        .wr1_data (wr1_data)
    );
endmodule

// File: rtl/pf_checker.sv
module pf_checker #(
    parameter int DW = 64,
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          l0_valid,
    input logic          l0_wide,
    input logic [AW-1:0] l0_raddr,
    input logic [AW-1:0] l0_waddr,
    input logic          l0_wen,
    input logic [DW-1:0] l0_wdata,
    input logic          l1_valid,
    input logic [AW-1:0] l1_waddr,
    input logic          l1_wen,
    input logic [DW-1:0] l1_wdata,
    input logic [DW-1:0] l0_rdata,
    input logic [DW-1:0] l1_rdata,
    input logic          l0_stall,
    input logic          l1_stall
);
    logic wide_now, l0_narrow_wr, l1_wr_ok;
    assign wide_now     = l0_valid && l0_wide && !l0_stall;
    assign l0_narrow_wr = l0_valid && !l0_wide && l0_wen;
    assign l1_wr_ok     = l1_valid && !l1_stall && l1_wen;

    // R6
    p_wide_holds_l1_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wide_now && l1_valid && !l0_stall) |-> l1_stall);

    // R9
    p_stall_needs_wide_r9: assert property (@(posedge clk) disable iff (!rst_n)
        l1_stall |-> (l0_valid && l0_wide));
    p_stall_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(l0_stall && l1_stall));

    // R7
    p_owed_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        l1_stall |=> !l1_stall);
    p_l0_stall_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        l0_stall |-> $past(l1_stall));

    // R2
    p_write_visible_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (l0_narrow_wr && !(l1_wr_ok && l1_waddr == l0_waddr))
        |=> (wide_now || l0_raddr != $past(l0_waddr) || l0_rdata == $past(l0_wdata)));

    // R3
    p_collide_l1_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (l0_narrow_wr && l1_wr_ok && l1_waddr == l0_waddr)
        |=> (wide_now || l0_raddr != $past(l1_waddr) || l0_rdata == $past(l1_wdata)));

    // R4 / R5
    p_wide_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wide_now && l0_wen)
        |=> (!wide_now || l0_raddr[AW-1:1] != $past(l0_waddr[AW-1:1])
             || (l0_rdata == $past(l0_wdata) && l1_rdata == $past(l1_wdata))));
endmodule

bind pf_regfile pf_checker #(.DW(DW), .AW(AW)) u_pf_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .l0_valid (l0_valid),
    .l0_wide  (l0_wide),
    .l0_raddr (l0_raddr),
    .l0_waddr (l0_waddr),
    .l0_wen   (l0_wen),
    .l0_wdata (l0_wdata),
    .l1_valid (l1_valid),
    .l1_waddr (l1_waddr),
    .l1_wen   (l1_wen),
    .l1_wdata (l1_wdata),
    .l0_rdata (l0_rdata),
    .l1_rdata (l1_rdata),
    .l0_stall (l0_stall),
    .l1_stall (l1_stall)
);

// File: tb/pf_regfile_test.sv
`timescale 1ns/1ps
module pf_regfile_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        l0_valid, l0_wide, l0_wen, l1_valid, l1_wen;
    logic [5:0]  l0_raddr, l0_waddr, l1_raddr, l1_waddr;
    logic [63:0] l0_wdata, l1_wdata, l0_rdata, l1_rdata;
    logic        l0_stall, l1_stall;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pf_regfile uut (
        .clk(clk), .rst_n(rst_n),
        .l0_valid(l0_valid), .l0_wide(l0_wide), .l0_raddr(l0_raddr),
        .l0_waddr(l0_waddr), .l0_wen(l0_wen), .l0_wdata(l0_wdata),
        .l1_valid(l1_valid), .l1_raddr(l1_raddr), .l1_waddr(l1_waddr),
        .l1_wen(l1_wen), .l1_wdata(l1_wdata),
        .l0_rdata(l0_rdata), .l1_rdata(l1_rdata),
        .l0_stall(l0_stall), .l1_stall(l1_stall)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        l0_valid = 0; l0_wide = 0; l0_wen = 0; l0_raddr = 0; l0_waddr = 0; l0_wdata = 0;
        l1_valid = 0; l1_wen = 0; l1_raddr = 0; l1_waddr = 0; l1_wdata = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(input logic [5:0] a, output logic [63:0] d);
        l0_valid = 0; l0_wide = 0; l0_raddr = a;
        #1 d = l0_rdata;
    endtask

    task automatic t_reset();
        logic [63:0] d;
        for (int a = 0; a < 64; a += 21) begin
            rd(6'(a), d);
            chk("R1 entry zero", d, 64'h0);
        end
        l1_raddr = 6'd63; #1 chk("R1 lane1 zero", l1_rdata, 64'h0);
        chk("R1 stalls low", {62'h0, l0_stall, l1_stall}, 64'h0);
    endtask

    task automatic t_narrow();
        logic [63:0] d;
        l0_valid = 1; l0_wen = 1; l0_waddr = 6'd5; l0_wdata = 64'hA5A5_0000_0000_0005;
        l1_valid = 1; l1_wen = 1; l1_waddr = 6'd9; l1_wdata = 64'h9999_0000_0000_0009;
        l0_raddr = 6'd5; l1_raddr = 6'd9;
        #1 chk("R2 no bypass lane0", l0_rdata, 64'h0);
        chk("R2 no bypass lane1", l1_rdata, 64'h0);
        chk("R9 no stall narrow", {62'h0, l0_stall, l1_stall}, 64'h0);
        tick(); idle();
        rd(6'd5, d); chk("R2 lane0 write", d, 64'hA5A5_0000_0000_0005);
        l1_raddr = 6'd9; #1 chk("R2 lane1 read", l1_rdata, 64'h9999_0000_0000_0009);
    endtask

    task automatic t_collide();
        logic [63:0] d;
        l0_valid = 1; l0_wen = 1; l0_waddr = 6'd12; l0_wdata = 64'hC0C0;
        l1_valid = 1; l1_wen = 1; l1_waddr = 6'd12; l1_wdata = 64'hD1D1;
        tick(); idle();
        rd(6'd12, d); chk("R3 lane1 wins", d, 64'hD1D1);
    endtask

    task automatic t_wide();
        logic [63:0] d;
        l0_valid = 1; l0_wide = 1; l0_wen = 1; l0_waddr = 6'd7;
        l0_wdata = 64'hEEEE_0000_0000_0006; l1_wdata = 64'hFFFF_0000_0000_0007;
        l1_waddr = 6'd20; l1_wen = 1;
        tick(); idle();
        rd(6'd6, d);  chk("R4 low half", d, 64'hEEEE_0000_0000_0006);
        rd(6'd7, d);  chk("R8 high half narrow", d, 64'hFFFF_0000_0000_0007);
        rd(6'd20, d); chk("R4 lane1 addr ignored", d, 64'h0);
        l0_valid = 1; l0_wide = 1; l0_raddr = 6'd7; l1_raddr = 6'd5;
        #1 chk("R5 wide low", l0_rdata, 64'hEEEE_0000_0000_0006);
        chk("R5 wide high", l1_rdata, 64'hFFFF_0000_0000_0007);
        idle();
        l0_valid = 1; l0_wen = 1; l0_waddr = 6'd6; l0_wdata = 64'h1234;
        tick(); idle();
        l0_valid = 1; l0_wide = 1; l0_raddr = 6'd6;
        #1 chk("R8 narrow seen in wide", l0_rdata, 64'h1234);
        chk("R8 other half kept", l1_rdata, 64'hFFFF_0000_0000_0007);
        idle();
    endtask

    task automatic t_stall();
        logic [63:0] d;
        l0_valid = 1; l0_wide = 1; l0_wen = 1; l0_waddr = 6'd20;
        l0_wdata = 64'h2020; l1_wdata = 64'h2121;
        l1_valid = 1; l1_wen = 1; l1_waddr = 6'd30;
        #1 chk("R6 l1 stalled", {63'h0, l1_stall}, 64'h1);
        chk("R6 l0 not stalled", {63'h0, l0_stall}, 64'h0);
        tick();
        l0_waddr = 6'd22; l0_wdata = 64'h2222; l1_wdata = 64'h3030;
        #1 chk("R7 owed l0 stalled", {63'h0, l0_stall}, 64'h1);
        chk("R7 owed l1 free", {63'h0, l1_stall}, 64'h0);
        tick(); idle();
        rd(6'd30, d); chk("R7 l1 write done", d, 64'h3030);
        rd(6'd22, d); chk("R7 stalled wide dropped", d, 64'h0);
        rd(6'd21, d); chk("R6 wide went ahead", d, 64'h2121);
        l0_valid = 1; l0_wide = 1; l0_wen = 1; l0_waddr = 6'd40;
        l0_wdata = 64'h4040; l1_wdata = 64'h4141; l1_valid = 1;
        tick();
        l1_valid = 0; l0_waddr = 6'd42; l0_wdata = 64'h4242; l1_wdata = 64'h4343;
        #1 chk("R7 owed no l1 no stall", {62'h0, l0_stall, l1_stall}, 64'h0);
        tick(); idle();
        rd(6'd43, d); chk("R7 owed wide issued", d, 64'h4343);
        l0_valid = 1; l0_wide = 1; l1_valid = 1;
        #1 chk("R9 free again stalls l1", {62'h0, l0_stall, l1_stall}, 64'h1);
        idle();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_narrow();
        t_collide();
        t_wide();
        t_stall();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule